// File: doc/BRIEF.md
# Sector Protection Register Bank

This block keeps one small protection register for each 64 KB sector of a flash memory and turns them, together with two hardware protect pins, into per-sector qualifiers. The command controller reads `sec_rd_ok` before it returns array data and reads `sec_wr_ok` before it starts a program or erase. Software reaches the registers through a simple indexed write/read port. Each register holds a read-inhibit bit, a write-inhibit bit and a sticky freeze bit. Once the freeze bit is set, the register stays as it is until reset.

Two active-high protect pins override the registers. `pin_boot_prot` guards only the highest sector, which is the boot sector. `pin_main_prot` guards every other sector. While the controller reports a suspended program or erase on `op_held`, the bank keeps using the pin levels it had before the suspend. Any pin change reaches the qualifiers as soon as `op_held` drops. The bank also gates array read data: a sector whose read-inhibit bit is set reads back as zero.

Top module: `sector_lock_bank`

## Requirements
- R1: There are NUM_SECTORS (default 16) registers. `cfg_rdata` shows the register selected by `cfg_addr` in the same cycle, with read-inhibit in bit 2, freeze in bit 1, write-inhibit in bit 0, and bits 7..3 always 0.
- R2: After reset every register reads 01h: write-inhibit set, read-inhibit and freeze clear. So all `sec_wr_ok` bits are 0 and all `sec_rd_ok` bits are 1.
- R3: A write to an unfrozen register loads `cfg_wdata[2:0]` into it on the clock edge and ignores `cfg_wdata[7:3]`. No other register changes.
- R4: While a register's freeze bit is set, writes to that register are ignored: all three bits keep their values.
- R5: Only reset clears the freeze bit. After reset, that register reads 01h again and accepts writes.
- R6: `sec_rd_ok[i]` is the inverse of read-inhibit i. With both pins low, `sec_wr_ok[i]` is the inverse of write-inhibit i.
- R7: While the effective boot pin is high, `sec_wr_ok[NUM_SECTORS-1]` is 0 and the other sectors are unaffected.
- R8: While the effective main pin is high, `sec_wr_ok` of every sector below NUM_SECTORS-1 is 0 and the boot sector is unaffected.
- R9: While `op_held` is high, changes on the protect pins do not alter `sec_wr_ok`. Once `op_held` is low, the live pin levels act in that same cycle.
- R10: `arr_dout` equals `arr_din` when `sec_rd_ok[arr_sector]` is 1, and 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Sector register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register contents |
| pin_boot_prot | input | 1 | Boot sector write protect, active high |
| pin_main_prot | input | 1 | Write protect for all other sectors, active high |
| op_held | input | 1 | High while a program/erase is suspended |
| sec_rd_ok | output | 16 | Per-sector read allowed |
| sec_wr_ok | output | 16 | Per-sector write allowed |
| arr_sector | input | 4 | Sector of the current array read |
| arr_din | input | 8 | Raw array read data |
| arr_dout | output | 8 | Gated array read data |

## Verification
Several rules are checked on every cycle by assertions: a frozen register stays stable, the effective pin levels stay fixed while a suspend lasts, each effective pin forces its sectors' write qualifiers low, and array data from a read-inhibited sector is zero. The bench scenarios cover the rest. They show the reset values as seen through the read port, that writes go only to the addressed register and ignore the upper data bits, and that freeze is cleared only by reset. They also show that a pin change made during a suspend takes effect exactly when the suspend ends.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int CFG_W = 8;

    typedef struct packed {
        logic rd_inh;   // bit 2
        logic frozen;   // bit 1
        logic wr_inh;   // bit 0
    } lock_t;

    localparam lock_t LOCK_RST = '{rd_inh: 1'b0, frozen: 1'b0, wr_inh: 1'b1};

    function automatic lock_t field_of(input logic [2:0] d);
        return lock_t'(d);
    endfunction

    function automatic logic [CFG_W-1:0] view_of(input lock_t l);
        return {{(CFG_W-3){1'b0}}, l};
    endfunction

endpackage

// File: rtl/sl_lock_cell.sv
module sl_lock_cell
    import sl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_bits,
    output lock_t      state
);

    always_ff @(posedge clk) begin
        if (rst)
            state <= LOCK_RST;
        else if (wr_en && !state.frozen)
            state <= field_of(wr_bits);
    end

    // R4: a frozen register keeps all bits
    a_r4_frozen_stable: assert property (@(posedge clk) disable iff (rst)
        state.frozen |=> (state.frozen && $stable(state.rd_inh) && $stable(state.wr_inh)));

    // R2: value after reset
    a_r2_reset_value: assert property (@(posedge clk)
        $past(rst) |-> (state == LOCK_RST));

endmodule

// File: rtl/sl_pin_defer.sv
module sl_pin_defer (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic boot_in,
    input  logic main_in,
    output logic boot_eff,
    output logic main_eff
);

    logic boot_q, main_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_q <= 1'b0;
            main_q <= 1'b0;
        end else if (!hold) begin
            boot_q <= boot_in;
            main_q <= main_in;
        end
    end

    always_comb begin
        boot_eff = hold ? boot_q : boot_in;
        main_eff = hold ? main_q : main_in;
    end

    // R9: effective pins frozen across a suspend
    a_r9_hold_pins: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold)) |-> ($stable(boot_eff) && $stable(main_eff)));

endmodule

// File: rtl/sl_qualify.sv
module sl_qualify
    import sl_pkg::*;
#(
    parameter int NUM_SECTORS = 16
) (
    input  lock_t                  locks [NUM_SECTORS],
    input  logic                   boot_eff,
    input  logic                   main_eff,
    output logic [NUM_SECTORS-1:0] rd_ok,
    output logic [NUM_SECTORS-1:0] wr_ok
);

    localparam int TOP_IDX = NUM_SECTORS - 1;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sec
        logic pin_block;
        if (i == TOP_IDX) begin : g_boot
            assign pin_block = boot_eff;
        end else begin : g_main
            assign pin_block = main_eff;
        end
        assign rd_ok[i] = !locks[i].rd_inh;
        assign wr_ok[i] = !locks[i].wr_inh && !pin_block;
    end

endmodule

// File: rtl/sector_lock_bank.sv
module sector_lock_bank
    import sl_pkg::*;
#(
    parameter int NUM_SECTORS = 16,
    parameter int DATA_W      = 8,
    localparam int ADDR_W     = $clog2(NUM_SECTORS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [CFG_W-1:0]       cfg_rdata,
    input  logic                   pin_boot_prot,
    input  logic                   pin_main_prot,
    input  logic                   op_held,
    output logic [NUM_SECTORS-1:0] sec_rd_ok,
    output logic [NUM_SECTORS-1:0] sec_wr_ok,
    input  logic [ADDR_W-1:0]      arr_sector,
    input  logic [DATA_W-1:0]      arr_din,
    output logic [DATA_W-1:0]      arr_dout
);

    localparam int TOP_IDX = NUM_SECTORS - 1;

    lock_t locks [NUM_SECTORS];
    logic  boot_eff, main_eff;
    logic  unused_hi;

    assign unused_hi = ^cfg_wdata[CFG_W-1:3];

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_cell
        sl_lock_cell i_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (cfg_we && (cfg_addr == ADDR_W'(i))),
            .wr_bits(cfg_wdata[2:0]),
            .state  (locks[i])
        );
    end

    sl_pin_defer i_pins (
        .clk     (clk),
        .rst     (rst),
        .hold    (op_held),
        .boot_in (pin_boot_prot),
        .main_in (pin_main_prot),
        .boot_eff(boot_eff),
        .main_eff(main_eff)
    );

    sl_qualify #(.NUM_SECTORS(NUM_SECTORS)) i_qual (
        .locks   (locks),
        .boot_eff(boot_eff),
        .main_eff(main_eff),
        .rd_ok   (sec_rd_ok),
        .wr_ok   (sec_wr_ok)
    );

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) < NUM_SECTORS)
            cfg_rdata = view_of(locks[cfg_addr]) | {{(CFG_W-1){1'b0}}, unused_hi & 1'b0};
    end

    always_comb begin
        arr_dout = '0;
        if (int'(arr_sector) < NUM_SECTORS && sec_rd_ok[arr_sector])
            arr_dout = arr_din;
    end

    // R7: boot pin blocks the top sector
    a_r7_boot_pin: assert property (@(posedge clk) disable iff (rst)
        boot_eff |-> !sec_wr_ok[TOP_IDX]);

    // R8: main pin blocks all lower sectors
    a_r8_main_pin: assert property (@(posedge clk) disable iff (rst)
        main_eff |-> (sec_wr_ok[TOP_IDX-1:0] == '0));

    // R10: read-inhibited sector yields zero data
    a_r10_read_gate: assert property (@(posedge clk) disable iff (rst)
        !sec_rd_ok[arr_sector] |-> (arr_dout == '0));

    // R1: upper register bits always zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[CFG_W-1:3] == '0);

endmodule

// File: tb/test_sector_lock_bank.sv
module test_sector_lock_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        pin_boot_prot, pin_main_prot, op_held;
    logic [15:0] sec_rd_ok, sec_wr_ok;
    logic [3:0]  arr_sector;
    logic [7:0]  arr_din, arr_dout;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    sector_lock_bank i_sector_lock_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_boot_prot(pin_boot_prot), .pin_main_prot(pin_main_prot),
        .op_held(op_held), .sec_rd_ok(sec_rd_ok), .sec_wr_ok(sec_wr_ok),
        .arr_sector(arr_sector), .arr_din(arr_din), .arr_dout(arr_dout)
    );

    // {addr, wdata, expected readback}
    localparam logic [19:0] VEC [7] = '{
        {4'd0,  8'h00, 8'h00},
        {4'd1,  8'h04, 8'h04},
        {4'd2,  8'hF8, 8'h00},
        {4'd3,  8'h05, 8'h05},
        {4'd15, 8'h00, 8'h00},
        {4'd14, 8'hE1, 8'h01},
        {4'd6,  8'h07 & 8'h05, 8'h05}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        pin_boot_prot = 1'b0; pin_main_prot = 1'b0; op_held = 1'b0;
        arr_sector = '0; arr_din = '0;
        do_reset();

        // R2 reset state
        for (int i = 0; i < 16; i++) begin
            rd_reg(4'(i), r);
            check("R2 reset value", r, 8'h01);
        end
        check("R2 wr_ok after reset", sec_wr_ok, 16'h0000);
        check("R2 rd_ok after reset", sec_rd_ok, 16'hFFFF);

        // R1 R3 R6 vector walk
        for (int k = 0; k < 7; k++) begin
            logic [3:0] a;
            logic [7:0] d, e;
            {a, d, e} = VEC[k];
            wr_reg(a, d);
            rd_reg(a, r);
            check("R1 R3 readback", r, e);
            check("R6 rd_ok", sec_rd_ok[a], !e[2]);
            check("R6 wr_ok", sec_wr_ok[a], !e[0]);
        end

        // R3 untouched register
        rd_reg(4'd4, r);
        check("R3 neighbour unchanged", r, 8'h01);

        // R4 freeze
        wr_reg(4'd5, 8'h02);
        rd_reg(4'd5, r);
        check("R4 freeze set", r, 8'h02);
        wr_reg(4'd5, 8'h05);
        rd_reg(4'd5, r);
        check("R4 frozen write ignored", r, 8'h02);
        check("R4 wr_ok unchanged", sec_wr_ok[5], 1'b1);
        wr_reg(4'd5, 8'h00);
        rd_reg(4'd5, r);
        check("R5 freeze not cleared by write", r, 8'h02);

        // R7 boot pin
        pin_boot_prot = 1'b1; #1;
        check("R7 boot blocked", sec_wr_ok[15], 1'b0);
        check("R7 others free", sec_wr_ok[0], 1'b1);
        pin_boot_prot = 1'b0;

        // R8 main pin
        pin_main_prot = 1'b1; #1;
        check("R8 lower blocked", sec_wr_ok[14:0], 15'h0);
        check("R8 boot free", sec_wr_ok[15], 1'b1);
        @(negedge clk);
        pin_main_prot = 1'b0; #1;
        check("R8 released", sec_wr_ok[0], 1'b1);

        // R9 deferral
        @(negedge clk);
        op_held = 1'b1;
        @(negedge clk);
        pin_boot_prot = 1'b1;
        pin_main_prot = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        check("R9 boot deferred", sec_wr_ok[15], 1'b1);
        check("R9 main deferred", sec_wr_ok[0], 1'b1);
        op_held = 1'b0; #1;
        check("R9 boot applied", sec_wr_ok[15], 1'b0);
        check("R9 main applied", sec_wr_ok[0], 1'b0);
        @(negedge clk);
        pin_boot_prot = 1'b0; pin_main_prot = 1'b0; #1;

        // R10 data gating
        arr_din = 8'hA5; arr_sector = 4'd1; #1;
        check("R10 inhibited zero", arr_dout, 8'h00);
        arr_sector = 4'd0; #1;
        check("R10 open passes", arr_dout, 8'hA5);

        // R5 reset clears freeze
        do_reset();
        rd_reg(4'd5, r);
        check("R5 reset value", r, 8'h01);
        wr_reg(4'd5, 8'h00);
        rd_reg(4'd5, r);
        check("R5 writable after reset", r, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule